// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block is a host-programmable controller for three 8-bit parallel ports, called A, B and C. A host reaches it through a 2-bit register address, separate 8-bit write and read data buses, and write and read strobes. Addresses 0, 1 and 2 reach the output latches of ports A, B and C. Address 3 reaches the control register. A control write does one of two things. With bit 7 high it programs the modes and directions of both port groups. With bit 7 low it sets or clears one bit of the port C latch.

From the control word the block derives an input mask and an output mask for each port. A handshake mode claims some port C lines, and those lines are removed from both masks. A separate handshake block overlays them with its own signals. Each pin output carries the latch value where the bit is an output and logic 1 everywhere else. A port read merges the pin values on input bits with the latch values on output bits. Register writes take effect on the rising clock edge. Read data is combinational. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `pport_ctrl`

## Requirements
- R1: While reset is held, and after it is released, the control register holds 0x9B. Every port is then an input in mode 0, all three pin outputs are 0xFF, and a read of each port returns its pin inputs.
- R2: A write to address 3 with bit 7 high stores the whole byte, and a later read of address 3 returns it.
- R3: Control bit 4 sets the direction of port A, bit 1 that of port B, bit 3 that of port C bits 7:4 and bit 0 that of port C bits 3:0. A value of 1 means input.
- R4: A port read returns the pin input on input bits and the latch on output bits. The pin output carries the latch on output bits and 1 on every other bit.
- R5: When control bits 6:5 are 01 (group A mode 1), port C bits 5:3 are reserved. They read as 0 and drive 1.
- R6: When control bit 6 is 1 (group A mode 2, codes 10 and 11 alike), port C bits 7:3 are reserved. Port A then drives its whole latch and reads back the OR of pins and latch.
- R7: When control bit 2 is 1 (group B mode 1), port C bits 2:0 are reserved. They read as 0 and drive 1.
- R8: A mode program clears the latches of all three ports.
- R9: A write to address 3 with bit 7 low sets port C latch bit number wr_data[3:1] to wr_data[0]. It leaves the other latch bits and the control register unchanged.
- R10: With the write strobe low, no register changes. With the read strobe low, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 = A, 1 = B, 2 = C, 3 = control |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Host read data |
| pa_in | input | 8 | Port A pin values |
| pb_in | input | 8 | Port B pin values |
| pc_in | input | 8 | Port C pin values |
| pa_out | output | 8 | Port A pin drive |
| pb_out | output | 8 | Port B pin drive |
| pc_out | output | 8 | Port C pin drive |

## Verification
The properties assume that the strobes and address are driven to known values at every clock edge once reset is released. They also assume that the host does not issue writes during the two synchronizer cycles after reset. The bench keeps within this by changing inputs only on the falling edge. It also waits several cycles after releasing reset before it touches the host interface. Every one of the 128 mode-program words is swept. For each word the bench drives pin and latch patterns that differ per word, so reserved and direction-masked bits are exercised with both polarities.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int DW      = 8;
  localparam int NPORT   = 3;
  localparam int IDX_W   = $clog2(DW);
  localparam int PA      = 0;
  localparam int PB      = 1;
  localparam int PC      = 2;
  localparam logic [DW-1:0] RESET_WORD = 8'h9B;

  // Port C lines claimed by handshake modes
  localparam logic [DW-1:0] RES_A_STROBED = 8'h38;
  localparam logic [DW-1:0] RES_A_BIDIR   = 8'hF8;
  localparam logic [DW-1:0] RES_B_STROBED = 8'h07;

  typedef enum logic [1:0] {
    GA_BASIC    = 2'd0,
    GA_STROBED  = 2'd1,
    GA_BIDIR    = 2'd2
  } ga_mode_e;

  typedef struct packed {
    logic [DW-1:0] in_m;
    logic [DW-1:0] out_m;
  } mask_t;
endpackage

// File: rtl/pport_cfg.sv
module pport_cfg
  import pport_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_prog,
  input  logic [DW-1:0]         wr_data,
  output logic [DW-1:0]         ctrl_word,
  output mask_t [NPORT-1:0]     msk
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] ctrl_q, ctrl_d;
  ga_mode_e      ga_mode;
  logic          gb_strobed;
  logic [DW-1:0] c_res;

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (mode_prog) ctrl_d = wr_data;
  end

  // register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= RESET_WORD;
    else if (mode_prog) ctrl_q <= ctrl_d;
  end

  assign ctrl_word = ctrl_q;

  // mode decode: code 11 folds onto the bidirectional mode
  always_comb begin
    if (ctrl_q[6])      ga_mode = GA_BIDIR;
    else if (ctrl_q[5]) ga_mode = GA_STROBED;
    else                ga_mode = GA_BASIC;
    gb_strobed = ctrl_q[2];
  end

  always_comb begin
    c_res = '0;
    case (ga_mode)
      GA_STROBED: c_res = RES_A_STROBED;
      GA_BIDIR:   c_res = RES_A_BIDIR;
      default:    c_res = '0;
    endcase
    if (gb_strobed) c_res = c_res | RES_B_STROBED;
  end

  always_comb begin
    // port A
    if (ga_mode == GA_BIDIR) begin
      msk[PA].in_m  = '1;
      msk[PA].out_m = '1;
    end else begin
      msk[PA].in_m  = {DW{ctrl_q[4]}};
      msk[PA].out_m = {DW{~ctrl_q[4]}};
    end
    // port B
    msk[PB].in_m  = {DW{ctrl_q[1]}};
    msk[PB].out_m = {DW{~ctrl_q[1]}};
    // port C: nibble directions, minus handshake lines
    msk[PC].in_m  = {{HALF{ctrl_q[3]}},  {HALF{ctrl_q[0]}}}  & ~c_res;
    msk[PC].out_m = {{HALF{~ctrl_q[3]}}, {HALF{~ctrl_q[0]}}} & ~c_res;
  end
endmodule

// File: rtl/pport_latch.sv
module pport_latch
  import pport_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_prog,
  input  logic [NPORT-1:0]           wr_sel,
  input  logic                       bsr_stb,
  input  logic [IDX_W-1:0]           bsr_idx,
  input  logic                       bsr_val,
  input  logic [DW-1:0]              wr_data,
  output logic [NPORT-1:0][DW-1:0]   lat_q
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [DW-1:0] q, d;
    logic          en;

    if (p == PC) begin : g_bsr
      always_comb begin
        d = q;
        if (mode_prog)      d = '0;
        else if (wr_sel[p]) d = wr_data;
        else if (bsr_stb)   d[bsr_idx] = bsr_val;
      end
      assign en = mode_prog | wr_sel[p] | bsr_stb;
    end else begin : g_plain
      always_comb begin
        d = q;
        if (mode_prog)      d = '0;
        else if (wr_sel[p]) d = wr_data;
      end
      assign en = mode_prog | wr_sel[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign lat_q[p] = q;
  end
endmodule

// File: rtl/pport_view.sv
module pport_view
  import pport_pkg::*;
(
  input  logic [1:0]               addr,
  input  logic                     rd_en,
  input  logic [DW-1:0]            ctrl_word,
  input  mask_t [NPORT-1:0]        msk,
  input  logic [NPORT-1:0][DW-1:0] lat,
  input  logic [NPORT-1:0][DW-1:0] pins,
  output logic [NPORT-1:0][DW-1:0] drive,
  output logic [DW-1:0]            rd_data
);
  logic [NPORT-1:0][DW-1:0] merged;

  for (genvar p = 0; p < NPORT; p++) begin : g_mix
    assign drive[p]  = (lat[p] & msk[p].out_m) | ~msk[p].out_m;
    assign merged[p] = (pins[p] & msk[p].in_m) | (lat[p] & msk[p].out_m);
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (addr)
        2'd0:    rd_data = merged[PA];
        2'd1:    rd_data = merged[PB];
        2'd2:    rd_data = merged[PC];
        default: rd_data = ctrl_word;
      endcase
    end
  end
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  input  logic [7:0]    pa_in,
  input  logic [7:0]    pb_in,
  input  logic [7:0]    pc_in,
  output logic [7:0]    pa_out,
  output logic [7:0]    pb_out,
  output logic [7:0]    pc_out
);
  logic [1:0]               rst_pipe;
  logic                     rst_sync_n;
  logic                     ctrl_sel, mode_prog, bsr_stb;
  logic [NPORT-1:0]         wr_sel;
  logic [DW-1:0]            ctrl_word;
  mask_t [NPORT-1:0]        msk;
  logic [NPORT-1:0][DW-1:0] lat, pins, drive;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign ctrl_sel  = wr_en & (addr == 2'd3);
  assign mode_prog = ctrl_sel &  wr_data[7];
  assign bsr_stb   = ctrl_sel & ~wr_data[7];

  for (genvar p = 0; p < NPORT; p++) begin : g_sel
    assign wr_sel[p] = wr_en & (addr == 2'(p));
  end

  assign pins[PA] = pa_in;
  assign pins[PB] = pb_in;
  assign pins[PC] = pc_in;

  pport_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mode_prog (mode_prog),
    .wr_data   (wr_data),
    .ctrl_word (ctrl_word),
    .msk       (msk)
  );

  pport_latch u_lat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mode_prog (mode_prog),
    .wr_sel    (wr_sel),
    .bsr_stb   (bsr_stb),
    .bsr_idx   (wr_data[IDX_W:1]),
    .bsr_val   (wr_data[0]),
    .wr_data   (wr_data),
    .lat_q     (lat)
  );

  pport_view u_view (
    .addr      (addr),
    .rd_en     (rd_en),
    .ctrl_word (ctrl_word),
    .msk       (msk),
    .lat       (lat),
    .pins      (pins),
    .drive     (drive),
    .rd_data   (rd_data)
  );

  assign pa_out = drive[PA];
  assign pb_out = drive[PB];
  assign pc_out = drive[PC];
endmodule

// File: rtl/pport_ctrl_chk.sv
module pport_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [7:0] pb_out,
  input logic [7:0] pc_out,
  input logic [7:0] ctrl_word
);
  // R2
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wr_data[7]) |=> (ctrl_word == $past(wr_data)));

  // R8
  mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wr_data[7]) |=> (pb_out == {8{$past(wr_data[1])}}));

  // R9
  bsr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && !wr_data[7]) |=> (ctrl_word == $past(ctrl_word)));

  // R4
  in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[1] |-> (pb_out == 8'hFF));

  // R6
  bidir_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[6] |-> (pc_out[7:3] == 5'h1F));

  // R7
  gb_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[2] |-> (pc_out[2:0] == 3'h7));

  // R10
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (ctrl_word == $past(ctrl_word) && pb_out == $past(pb_out)
                && pc_out == $past(pc_out)));

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == 8'h00));
endmodule

bind pport_ctrl pport_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .addr      (addr),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .pb_out    (pb_out),
  .pc_out    (pc_out),
  .ctrl_word (ctrl_word)
);

// File: tb/tb_pport_ctrl.sv
module tb_pport_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wr_data, rd_data;
  logic [7:0] pa_in, pb_in, pc_in, pa_out, pb_out, pc_out;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pport_ctrl dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data),
    .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
    .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out)
  );

  // expected model state
  logic [7:0] m_ctrl;
  logic [7:0] m_lat [3];
  logic [7:0] m_in  [3];
  logic [7:0] m_out [3];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h (ctrl=%02h)", tag, act, exp, m_ctrl);
    end
  endtask

  // masks computed from the requirement text
  task automatic calc_masks(input logic [7:0] cw);
    logic [7:0] res;
    res = 8'h00;
    if (cw[6])      res = 8'hF8;
    else if (cw[5]) res = 8'h38;
    if (cw[2])      res = res | 8'h07;
    if (cw[6]) begin
      m_in[0] = 8'hFF; m_out[0] = 8'hFF;
    end else begin
      m_in[0] = cw[4] ? 8'hFF : 8'h00; m_out[0] = ~m_in[0];
    end
    m_in[1]  = cw[1] ? 8'hFF : 8'h00; m_out[1] = ~m_in[1];
    m_in[2]  = {cw[3] ? 4'hF : 4'h0, cw[0] ? 4'hF : 4'h0};
    m_out[2] = ~m_in[2];
    m_in[2]  = m_in[2]  & ~res;
    m_out[2] = m_out[2] & ~res;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1;
    d = rd_data;
    rd_en = 1'b0;
    #1;
  endtask

  function automatic logic [7:0] drv(input int p);
    return (m_lat[p] & m_out[p]) | ~m_out[p];
  endfunction

  function automatic logic [7:0] pin_of(input int p);
    return (p == 0) ? pa_in : (p == 1) ? pb_in : pc_in;
  endfunction

  task automatic check_all(input string tag);
    logic [7:0] r;
    chk({tag, " pa_out"}, pa_out, drv(0));
    chk({tag, " pb_out"}, pb_out, drv(1));
    chk({tag, " pc_out"}, pc_out, drv(2));
    for (int p = 0; p < 3; p++) begin
      rd(2'(p), r);
      chk({tag, " read"}, r, (pin_of(p) & m_in[p]) | (m_lat[p] & m_out[p]));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    string      tag;
    rst_n = 1'b0; addr = 2'd0; wr_en = 1'b0; rd_en = 1'b0; wr_data = 8'h00;
    pa_in = 8'hA5; pb_in = 8'h3C; pc_in = 8'h96;
    repeat (3) @(negedge clk);
    // R1 during reset
    rd(2'd3, r);
    chk("R1 ctrl in reset", r, 8'h9B);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_ctrl = 8'h9B;
    calc_masks(m_ctrl);
    for (int p = 0; p < 3; p++) m_lat[p] = 8'h00;
    rd(2'd3, r);
    chk("R1 ctrl after reset", r, 8'h9B);
    check_all("R1 reset");

    // R10 idle read strobe
    addr = 2'd3; #1;
    chk("R10 rd idle", rd_data, 8'h00);

    // sweep every mode-program word
    for (int w = 128; w < 256; w++) begin
      logic [7:0] cw;
      cw = 8'(w);
      // latch values before programming, to see them cleared
      wr(2'd0, ~cw); wr(2'd1, cw ^ 8'h66); wr(2'd2, cw + 8'd9);
      wr(2'd3, cw);
      m_ctrl = cw;
      calc_masks(cw);
      for (int p = 0; p < 3; p++) m_lat[p] = 8'h00;
      rd(2'd3, r);
      chk("R2 ctrl readback", r, cw);
      check_all("R8 cleared");

      if (cw[6])      tag = "R6 bidir";
      else if (cw[2]) tag = "R7 gb strobed";
      else if (cw[5]) tag = "R5 ga strobed";
      else            tag = "R3 basic";

      pa_in = cw ^ 8'h5A; pb_in = ~cw; pc_in = {cw[3:0], cw[7:4]} ^ 8'hC3;
      wr(2'd0, cw ^ 8'h3C); m_lat[0] = cw ^ 8'h3C;
      wr(2'd1, cw + 8'd7);  m_lat[1] = cw + 8'd7;
      wr(2'd2, ~cw ^ 8'h11); m_lat[2] = ~cw ^ 8'h11;
      check_all({tag, " R4"});

      // R9 one set/reset per word
      wr(2'd3, {4'h0, cw[2:0], cw[3]});
      m_lat[2][cw[2:0]] = cw[3];
      chk("R9 pc_out", pc_out, drv(2));
      rd(2'd3, r);
      chk("R9 ctrl kept", r, cw);

      // R10 write strobe low
      @(negedge clk);
      addr = 2'd0; wr_data = ~m_lat[0];
      @(negedge clk);
      addr = 2'd3; wr_data = 8'h80;
      @(negedge clk);
      chk("R10 pa_out no write", pa_out, drv(0));
      rd(2'd3, r);
      chk("R10 ctrl no write", r, cw);
    end

    // R9 full sweep in an all-output mode
    wr(2'd3, 8'h80);
    m_ctrl = 8'h80; calc_masks(8'h80);
    for (int p = 0; p < 3; p++) m_lat[p] = 8'h00;
    wr(2'd2, 8'h5A); m_lat[2] = 8'h5A;
    for (int b = 0; b < 16; b++) begin
      wr(2'd3, 8'(b));
      m_lat[2][b >> 1] = b[0];
      chk("R9 sweep", pc_out, m_lat[2]);
      for (int v = 0; v < 2; v++) begin
        wr(2'd3, {4'h0, 3'(b >> 1), 1'(v)});
        m_lat[2][b >> 1] = 1'(v);
        chk("R9 sweep", pc_out, m_lat[2]);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule